// File: doc/BRIEF.md
# Six-Step Commutation Gate Decoder

This block turns the commutation state of a three-phase brushless motor drive into the six gate-drive levels of the inverter bridge: one upper and one lower switch for each of the phases U, V and W. It holds a step index from 0 to 5. The index moves on by one each time the step timer sends a single-cycle advance strobe. A direction input picks the phase order. The active pair of switches is chopped by an incoming PWM signal, and a global disable input turns the whole bridge off.

Two conduction styles are available. In plain 120-degree conduction, exactly one upper and one lower switch conduct, and each advance hands conduction from one switch to the next in a single cycle. In overlap conduction, the switch that is being turned off stays on for a programmable number of clock cycles after the incoming switch turns on. That count is worked out elsewhere from the lead angle. A polarity strap picks the active level of the upper outputs, so the bridge can use either P-channel or N-channel upper transistors. All gate outputs come from registers, so they are free of glitches.

Top module: `sixstep_gate_decoder`

## Requirements
- R1: After reset the step index is 0, every lower output is 0, and every upper output sits at its inactive level (1 when `hs_pch_i`=1, 0 when `hs_pch_i`=0).
- R2: The step index advances by one on each cycle in which `advance_i` is 1, wraps from 5 to 0, and does not change in any other cycle.
- R3: Phase bit order on `hs_o` and `ls_o` is [0]=U, [1]=V, [2]=W. With `reverse_i`=0, the conducting (upper, lower) phases for steps 0 to 5 are (U,V) (U,W) (V,W) (V,U) (W,U) (W,V).
- R4: With `reverse_i`=1, the table of R3 is used with V and W swapped: (U,W) (U,V) (W,V) (W,U) (V,U) (V,W).
- R5: With `mode_120_i`=1, or with `overlap_cyc_i`=0, a new step shows at the outputs in the second cycle after its advance strobe. Outside an overlap interval, exactly one upper and one lower switch are on while PWM is high and the block is enabled.
- R6: With `mode_120_i`=0 and `overlap_cyc_i`=L>0, the outgoing switch stays on alongside the incoming switch for L cycles, beginning in the cycle where the new step first appears. After that, only the new step's pair conducts.
- R7: When `pwm_i` is 0, all six outputs are inactive one cycle later. When `pwm_i` is 1, the conducting pair returns one cycle later.
- R8: When `disable_i` is 1, all six outputs are inactive one cycle later, whatever the polarity.
- R9: Lower outputs are active high. Upper outputs are active low when `hs_pch_i`=1 and active high when `hs_pch_i`=0.
- R10: No phase ever has its upper and lower switch on together. If the outgoing and incoming masks of an overlap would turn on both switches of a phase (which can happen when the direction changes during an overlap), both switches of that phase are held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance_i | input | 1 | Single-cycle strobe that moves the step index on |
| reverse_i | input | 1 | 1 = reverse phase order (U, W, V) |
| mode_120_i | input | 1 | 1 = plain 120-degree conduction, 0 = overlap conduction |
| overlap_cyc_i | input | OVL_W | Overlap interval length in clock cycles |
| pwm_i | input | 1 | Chopping signal applied to the conducting pair |
| disable_i | input | 1 | Forces all outputs inactive |
| hs_pch_i | input | 1 | 1 = upper outputs active low, 0 = active high |
| hs_o | output | 3 | Upper gate drives, [0]=U [1]=V [2]=W |
| ls_o | output | 3 | Lower gate drives, active high, [0]=U [1]=V [2]=W |

## Verification
A step index that is off by one, or that wraps wrongly, moves the conducting pair to the wrong phases. This shows up at the ports in the second cycle after the strobe that caused it. A wrong overlap counter makes the outgoing switch drop out too early or stay on too long. The bench sees this at the first and last cycles of the interval. A stale outgoing mask after a mid-overlap direction change would put both switches of one phase on. The bench drives that case and expects the phase to be held off in the very cycle the new step appears.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;
  localparam int PHASES = 3;
  localparam int STEPS  = 6;
  localparam int STEP_W = $clog2(STEPS);

  typedef logic [STEP_W-1:0] step_t;
  typedef logic [PHASES-1:0] pmask_t;

  typedef struct packed {
    pmask_t hi;
    pmask_t lo;
  } drive_t;
endpackage

// File: rtl/sixstep_step_ctr.sv
module sixstep_step_ctr
  import sixstep_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance_i,
  output step_t step_o
);
  localparam step_t LAST = step_t'(STEPS - 1);

  step_t step_q, step_d;
  logic  step_en;

  assign step_en = advance_i;

  always_comb begin
    step_d = (step_q == LAST) ? '0 : step_q + step_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  assign step_o = step_q;

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && step_q == LAST) |=> step_q == '0);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !advance_i |=> $stable(step_q));
  a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST);
endmodule

// File: rtl/sixstep_phase_map.sv
module sixstep_phase_map
  import sixstep_pkg::*;
(
  input  step_t  step_i,
  input  logic   reverse_i,
  output drive_t drive_o
);
  // Forward: upper phase = step/2, lower phase = ((step+1)/2 + 1) mod 3.
  // Reverse swaps phases 1 and 2 (V and W).
  logic [1:0] hi_fwd, lo_fwd, hi_sel, lo_sel;
  logic [2:0] lo_sum;

  function automatic logic [1:0] swap_vw(input logic [1:0] p);
    return (p == 2'd0) ? 2'd0 : 2'(3 - int'(p));
  endfunction

  always_comb begin
    hi_fwd = 2'(step_i >> 1);
    lo_sum = 3'((step_i + step_t'(1)) >> 1) + 3'd1;
    lo_fwd = (lo_sum >= 3'd3) ? 2'(lo_sum - 3'd3) : 2'(lo_sum);
    hi_sel = reverse_i ? swap_vw(hi_fwd) : hi_fwd;
    lo_sel = reverse_i ? swap_vw(lo_fwd) : lo_fwd;
    drive_o.hi = pmask_t'(1) << hi_sel;
    drive_o.lo = pmask_t'(1) << lo_sel;
  end
endmodule

// File: rtl/sixstep_overlap_tmr.sv
module sixstep_overlap_tmr
  import sixstep_pkg::*;
#(
  parameter int OVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance_i,
  input  logic             overlap_en_i,
  input  logic [OVL_W-1:0] overlap_cyc_i,
  input  drive_t           cur_drive_i,
  output drive_t           prev_drive_o,
  output logic             active_o
);
  logic [OVL_W-1:0] cnt_q, cnt_d;
  drive_t           prev_q, prev_d;
  logic             cnt_en, prev_en, start;

  assign start   = advance_i && overlap_en_i && (overlap_cyc_i != '0);
  assign prev_en = advance_i;
  assign cnt_en  = start || (cnt_q != '0) || advance_i;

  always_comb begin
    prev_d = cur_drive_i;
    if (start)          cnt_d = overlap_cyc_i;
    else if (advance_i) cnt_d = '0;
    else                cnt_d = cnt_q - OVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (prev_en) prev_q <= prev_d;
  end

  assign prev_drive_o = prev_q;
  assign active_o     = (cnt_q != '0);

  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == $past(overlap_cyc_i));
  a_r5_no_overlap_120: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !overlap_en_i) |=> !active_o);
  a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !advance_i) |=> cnt_q == $past(cnt_q) - OVL_W'(1));
endmodule

// File: rtl/sixstep_out_stage.sv
module sixstep_out_stage
  import sixstep_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  drive_t cur_drive_i,
  input  drive_t prev_drive_i,
  input  logic   overlap_act_i,
  input  logic   pwm_i,
  input  logic   disable_i,
  input  logic   hs_pch_i,
  output pmask_t hs_o,
  output pmask_t ls_o
);
  pmask_t want_hi, want_lo, hi_d, lo_d, hi_q, lo_q;
  logic   gate_ok;

  assign gate_ok = pwm_i && !disable_i;
  assign want_hi = cur_drive_i.hi | (overlap_act_i ? prev_drive_i.hi : '0);
  assign want_lo = cur_drive_i.lo | (overlap_act_i ? prev_drive_i.lo : '0);

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    logic clash;
    assign clash   = want_hi[p] && want_lo[p];
    assign hi_d[p] = want_hi[p] && !clash && gate_ok;
    assign lo_d[p] = want_lo[p] && !clash && gate_ok;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[p] <= 1'b0;
        lo_q[p] <= 1'b0;
      end else begin
        hi_q[p] <= hi_d[p];
        lo_q[p] <= lo_d[p];
      end
    end

    assign hs_o[p] = hi_q[p] ^ hs_pch_i;
    assign ls_o[p] = lo_q[p];
  end

  a_r7_pwm_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_i |=> (hi_q == '0 && lo_q == '0));
  a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> (hi_q == '0 && lo_q == '0));
  a_r5_single_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (!overlap_act_i && gate_ok) |=> ($countones(hi_q) == 1 && $countones(lo_q) == 1));
endmodule

// File: rtl/sixstep_gate_decoder.sv
module sixstep_gate_decoder
  import sixstep_pkg::*;
#(
  parameter int OVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance_i,
  input  logic             reverse_i,
  input  logic             mode_120_i,
  input  logic [OVL_W-1:0] overlap_cyc_i,
  input  logic             pwm_i,
  input  logic             disable_i,
  input  logic             hs_pch_i,
  output logic [2:0]       hs_o,
  output logic [2:0]       ls_o
);
  step_t  step;
  drive_t cur_drive, prev_drive;
  logic   ovl_act;

  sixstep_step_ctr i_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance_i (advance_i),
    .step_o    (step)
  );

  sixstep_phase_map i_map (
    .step_i    (step),
    .reverse_i (reverse_i),
    .drive_o   (cur_drive)
  );

  sixstep_overlap_tmr #(.OVL_W(OVL_W)) i_ovl (
    .clk           (clk),
    .rst_n         (rst_n),
    .advance_i     (advance_i),
    .overlap_en_i  (!mode_120_i),
    .overlap_cyc_i (overlap_cyc_i),
    .cur_drive_i   (cur_drive),
    .prev_drive_o  (prev_drive),
    .active_o      (ovl_act)
  );

  sixstep_out_stage i_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .cur_drive_i   (cur_drive),
    .prev_drive_i  (prev_drive),
    .overlap_act_i (ovl_act),
    .pwm_i         (pwm_i),
    .disable_i     (disable_i),
    .hs_pch_i      (hs_pch_i),
    .hs_o          (hs_o),
    .ls_o          (ls_o)
  );

  a_r10_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
    ((hs_o ^ {3{hs_pch_i}}) & ls_o) == 3'b000);
  a_r9_low_side_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    $past(disable_i) |-> (ls_o == 3'b000 && hs_o == {3{hs_pch_i}}));
endmodule

// File: tb/test_sixstep_gate_decoder.sv
module test_sixstep_gate_decoder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       advance_i, reverse_i, mode_120_i, pwm_i, disable_i, hs_pch_i;
  logic [7:0] overlap_cyc_i;
  logic [2:0] hs_o, ls_o;
  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  sixstep_gate_decoder #(.OVL_W(8)) i_sixstep_gate_decoder (
    .clk(clk), .rst_n(rst_n), .advance_i(advance_i), .reverse_i(reverse_i),
    .mode_120_i(mode_120_i), .overlap_cyc_i(overlap_cyc_i), .pwm_i(pwm_i),
    .disable_i(disable_i), .hs_pch_i(hs_pch_i), .hs_o(hs_o), .ls_o(ls_o)
  );

  // Expected masks from the tables of R3 and R4, bits [0]=U [1]=V [2]=W.
  function automatic logic [5:0] pair(input int s, input logic rev);
    logic [2:0] h, l;
    case (s)
      0: begin h = 3'b001; l = 3'b010; end
      1: begin h = 3'b001; l = 3'b100; end
      2: begin h = 3'b010; l = 3'b100; end
      3: begin h = 3'b010; l = 3'b001; end
      4: begin h = 3'b100; l = 3'b001; end
      default: begin h = 3'b100; l = 3'b010; end
    endcase
    if (rev) begin
      h = {h[1], h[2], h[0]};
      l = {l[1], l[2], l[0]};
    end
    return {h, l};
  endfunction

  task automatic check(input string req, input logic [2:0] on_hi, input logic [2:0] on_lo);
    logic [2:0] exp_hs;
    exp_hs = on_hi ^ {3{hs_pch_i}};
    checks++;
    if (hs_o !== exp_hs || ls_o !== on_lo) begin
      failures++;
      $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", req, hs_o, ls_o, exp_hs, on_lo);
    end
  endtask

  task automatic check_pair(input string req, input int s, input logic rev);
    logic [5:0] p;
    p = pair(s, rev);
    check(req, p[5:3], p[2:0]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; advance_i = 1'b0; reverse_i = 1'b0; mode_120_i = 1'b1;
    overlap_cyc_i = 8'd0; pwm_i = 1'b1; disable_i = 1'b0; hs_pch_i = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Pulse advance for one cycle; returns at the negedge after the strobe.
  task automatic pulse();
    advance_i = 1'b1;
    @(negedge clk);
    advance_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwm_i = 1'b1; disable_i = 1'b0; hs_pch_i = 1'b1;
    advance_i = 1'b0; reverse_i = 1'b0; mode_120_i = 1'b1; overlap_cyc_i = 8'd0;
    #1;
    check("R1 reset pch", 3'b000, 3'b000);
    hs_pch_i = 1'b0; #1;
    check("R1 reset nch", 3'b000, 3'b000);
    hs_pch_i = 1'b1;
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    check_pair("R1 step0 after reset", 0, 1'b0);
  endtask

  task automatic t_forward();
    do_reset();
    for (int k = 1; k <= 6; k++) begin
      pulse();
      @(negedge clk);
      check_pair((k == 6) ? "R2 wrap 5->0" : "R3 forward step", k % 6, 1'b0);
    end
  endtask

  task automatic t_reverse();
    do_reset();
    reverse_i = 1'b1;
    @(negedge clk);
    check_pair("R4 reverse step0", 0, 1'b1);
    for (int k = 1; k <= 6; k++) begin
      pulse();
      @(negedge clk);
      check_pair("R4 reverse step", k % 6, 1'b1);
    end
  endtask

  task automatic t_hold();
    do_reset();
    pulse(); pulse();
    @(negedge clk);
    repeat (5) @(negedge clk);
    check_pair("R2 hold without strobe", 2, 1'b0);
  endtask

  task automatic t_timing_120();
    do_reset();
    overlap_cyc_i = 8'd3;
    pulse();
    check_pair("R5 old step one cycle after strobe", 0, 1'b0);
    @(negedge clk);
    check_pair("R5 new step, no overlap in 120 mode", 1, 1'b0);
    mode_120_i = 1'b0; overlap_cyc_i = 8'd0;
    pulse();
    @(negedge clk);
    check_pair("R5 zero overlap length", 2, 1'b0);
  endtask

  task automatic t_overlap();
    do_reset();
    mode_120_i = 1'b0; overlap_cyc_i = 8'd3;
    pulse();
    check_pair("R6 before new step", 0, 1'b0);
    @(negedge clk);
    check("R6 overlap first cycle", 3'b001, 3'b110);
    @(negedge clk); @(negedge clk);
    check("R6 overlap last cycle", 3'b001, 3'b110);
    @(negedge clk);
    check_pair("R6 after overlap", 1, 1'b0);
    pulse();
    @(negedge clk);
    check("R6 upper overlap", 3'b011, 3'b100);
  endtask

  task automatic t_pwm();
    do_reset();
    pwm_i = 1'b0;
    @(negedge clk);
    check("R7 pwm low all off", 3'b000, 3'b000);
    pwm_i = 1'b1;
    @(negedge clk);
    check_pair("R7 pwm high restores", 0, 1'b0);
  endtask

  task automatic t_disable();
    do_reset();
    disable_i = 1'b1;
    @(negedge clk);
    check("R8 disable pch", 3'b000, 3'b000);
    hs_pch_i = 1'b0; #1;
    check("R8 disable nch", 3'b000, 3'b000);
    disable_i = 1'b0;
    @(negedge clk);
    check_pair("R9 nch upper active high", 0, 1'b0);
    hs_pch_i = 1'b1; #1;
    check_pair("R9 pch upper active low", 0, 1'b0);
  endtask

  task automatic t_guard();
    do_reset();
    mode_120_i = 1'b0; overlap_cyc_i = 8'd4;
    pulse();
    repeat (7) @(negedge clk);
    check_pair("R10 setup forward step1", 1, 1'b0);
    advance_i = 1'b1;
    @(negedge clk);
    advance_i = 1'b0; reverse_i = 1'b1;
    @(negedge clk);
    check("R10 clashing phase held off", 3'b001, 3'b010);
    repeat (4) @(negedge clk);
    check_pair("R10 reverse step2 after overlap", 2, 1'b1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_forward();
    t_reverse();
    t_hold();
    t_timing_120();
    t_overlap();
    t_pwm();
    t_disable();
    t_guard();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule